// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block decides, every cycle, how a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) keeps its operands correct. It reads the register specifiers and write controls held in the pipeline registers. From them it drives three sets of outputs. The first is the operand multiplexer selects for the execute stage. The second is the hold enables for the fetch and decode stages, together with a bubble-insert strobe for the decode/execute register. The third is a squash strobe for the three younger stages when a branch taken in the memory stage redirects the program counter.

The block also contains the integer register file. Writes land in the early part of the cycle and reads see them later in the same cycle, so a decode-stage read of a register under writeback returns the new value. A forwarding-enable pin selects between two modes. With forwarding on, only a load followed at once by a consumer costs a cycle. With forwarding off, every dependency waits until its producer reaches writeback, which costs two cycles for an adjacent pair.

All pins are plain control and data levels sampled from pipeline registers. There is no stream handshake at this boundary, because the pipeline itself applies the holds and bubbles this block produces.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: With forwarding on, an execute-stage operand whose nonzero register number equals the destination of a writing instruction in the execute/memory register gets select code 2'b10.
- R2: With forwarding on, an operand that matches only a writing instruction in the memory/writeback register gets select code 2'b01. With no match the code is 2'b00 (register file value).
- R3: When both the execute/memory and memory/writeback producers match the same operand, code 2'b10 wins.
- R4: Register 0, or a producer whose write enable is low, never causes a forward, a hold or a bubble.
- R5: With forwarding on, a load in execute whose destination equals either decode-stage source raises hold_fetch, hold_decode and bubble_ex together for that cycle.
- R6: With forwarding on, a non-load producer in execute that matches a decode source causes no hold and no bubble.
- R7: With forwarding off, both select codes are 2'b00. A hold and bubble are raised whenever a writing producer in execute or in memory matches a decode source, load or not.
- R8: A taken branch in the memory stage raises flush_young and forces hold_fetch, hold_decode and bubble_ex low, overriding any stall.
- R9: A register-file read of the register being written back in the same cycle returns the write data.
- R10: Register 0 always reads as zero, and writes to it are discarded.
- R11: After reset every register reads as zero. A written value is returned by later reads once writeback has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the register file |
| fwd_en | input | 1 | 1 = forwarding mode, 0 = stall-only mode |
| dec_rs | input | 5 | First source register of the decode-stage instruction (also read address A) |
| dec_rt | input | 5 | Second source register of the decode-stage instruction (also read address B) |
| ex_rs | input | 5 | First source register of the execute-stage instruction |
| ex_rt | input | 5 | Second source register of the execute-stage instruction |
| ex_rd | input | 5 | Destination of the execute-stage instruction |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Destination held in the execute/memory register |
| mem_wr_en | input | 1 | Execute/memory instruction writes a register |
| mem_br_taken | input | 1 | Branch in the memory stage is taken |
| wb_rd | input | 5 | Destination held in the memory/writeback register |
| wb_wr_en | input | 1 | Memory/writeback instruction writes a register |
| wb_data | input | 32 | Writeback data |
| rf_data_a | output | 32 | Register file read data for dec_rs |
| rf_data_b | output | 32 | Register file read data for dec_rt |
| fwd_sel_a | output | 2 | Execute operand A select: 00 file, 10 exec/mem, 01 mem/wb |
| fwd_sel_b | output | 2 | Execute operand B select, same codes |
| hold_fetch | output | 1 | Freeze the program counter and fetch stage |
| hold_decode | output | 1 | Freeze the fetch/decode register |
| bubble_ex | output | 1 | Load a no-op into the decode/execute register |
| flush_young | output | 1 | Squash the three younger instructions |

## Verification
The properties assume that the pipeline-register inputs change only between clock edges. They also assume that a producer marked as a load also has its write enable set, since the load-use rule is qualified by that enable. The bench keeps both register-file write and reset transitions synchronous. It sweeps every combination of register numbers 0 to 3 across the producer and consumer fields, with all enable, load, branch and mode bits, so register 0 and every equality pattern appear. Loads without a write enable also occur in the sweep, and the expected outputs treat them as having no dependency.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          fwd_en,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr,
  output fwd_sel_e      sel
);
  logic src_live;
  logic hit_mem;
  logic hit_wb;

  assign src_live = (src != '0);
  assign hit_mem  = src_live && mem_wr && (mem_rd == src);
  assign hit_wb   = src_live && wb_wr  && (wb_rd  == src);

  // Nearest producer takes precedence.
  always_comb begin
    sel = SEL_RF;
    if (fwd_en) begin
      if (hit_mem)     sel = SEL_MEM;
      else if (hit_wb) sel = SEL_WB;
    end
  end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                     fwd_en,
  input  logic [NSRC-1:0][AW-1:0]  dec_src,
  input  logic [AW-1:0]            ex_rd,
  input  logic                     ex_wr,
  input  logic                     ex_load,
  input  logic [AW-1:0]            mem_rd,
  input  logic                     mem_wr,
  input  logic                     br_taken,
  output logic                     hold_if,
  output logic                     hold_id,
  output logic                     bubble,
  output logic                     flush
);
  logic [NSRC-1:0] ex_hit;
  logic [NSRC-1:0] mem_hit;
  logic            ex_dep;
  logic            mem_dep;
  logic            need_stall;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic live;
    assign live       = (dec_src[s] != '0);
    assign ex_hit[s]  = live && ex_wr  && (ex_rd  == dec_src[s]);
    assign mem_hit[s] = live && mem_wr && (mem_rd == dec_src[s]);
  end

  assign ex_dep  = |ex_hit;
  assign mem_dep = |mem_hit;

  always_comb begin
    if (fwd_en) need_stall = ex_dep && ex_load;
    else        need_stall = ex_dep || mem_dep;
  end

  // A redirect squashes the younger stages; stalling them is moot.
  assign flush   = br_taken;
  assign hold_if = need_stall && !br_taken;
  assign hold_id = need_stall && !br_taken;
  assign bubble  = need_stall && !br_taken;
endmodule

// File: rtl/hz_regfile.sv
module hz_regfile #(
  parameter int AW  = 5,
  parameter int DW  = 32,
  parameter int NRD = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][DW-1:0]  rd_data
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] store [NREG];
  logic          wr_live;

  assign wr_live = wr_en && (wr_addr != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) store[r] <= '0;
    end else if (wr_live) begin
      store[wr_addr] <= wr_data;
    end
  end

  // Write lands before the read within a cycle: bypass the pending write.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_addr[p] == '0)                     rd_data[p] = '0;
      else if (wr_live && wr_addr == rd_addr[p]) rd_data[p] = wr_data;
      else                                       rd_data[p] = store[rd_addr[p]];
    end
  end
endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl
  import hz_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_en,
  input  logic [AW-1:0] dec_rs,
  input  logic [AW-1:0] dec_rt,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wr_en,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr_en,
  input  logic          mem_br_taken,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr_en,
  input  logic [DW-1:0] wb_data,
  output logic [DW-1:0] rf_data_a,
  output logic [DW-1:0] rf_data_b,
  output logic [1:0]    fwd_sel_a,
  output logic [1:0]    fwd_sel_b,
  output logic          hold_fetch,
  output logic          hold_decode,
  output logic          bubble_ex,
  output logic          flush_young
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][AW-1:0] ex_src;
  logic [NOPS-1:0][AW-1:0] dec_src;
  logic [NOPS-1:0][DW-1:0] rd_vals;
  fwd_sel_e                sel [NOPS];

  assign ex_src  = {ex_rt, ex_rs};
  assign dec_src = {dec_rt, dec_rs};

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    hz_fwd_sel #(.AW(AW)) u_sel (
      .fwd_en (fwd_en),
      .src    (ex_src[k]),
      .mem_rd (mem_rd),
      .mem_wr (mem_wr_en),
      .wb_rd  (wb_rd),
      .wb_wr  (wb_wr_en),
      .sel    (sel[k])
    );
  end

  assign fwd_sel_a = sel[0];
  assign fwd_sel_b = sel[1];

  hz_stall_unit #(.AW(AW), .NSRC(NOPS)) u_stall (
    .fwd_en   (fwd_en),
    .dec_src  (dec_src),
    .ex_rd    (ex_rd),
    .ex_wr    (ex_wr_en),
    .ex_load  (ex_is_load),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr_en),
    .br_taken (mem_br_taken),
    .hold_if  (hold_fetch),
    .hold_id  (hold_decode),
    .bubble   (bubble_ex),
    .flush    (flush_young)
  );

  hz_regfile #(.AW(AW), .DW(DW), .NRD(NOPS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wb_wr_en),
    .wr_addr (wb_rd),
    .wr_data (wb_data),
    .rd_addr (dec_src),
    .rd_data (rd_vals)
  );

  assign rf_data_a = rd_vals[0];
  assign rf_data_b = rd_vals[1];
endmodule

// File: rtl/hz_pipe_ctrl_chk.sv
module hz_pipe_ctrl_chk #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fwd_en,
  input logic [AW-1:0] dec_rs,
  input logic [AW-1:0] ex_rs,
  input logic [AW-1:0] ex_rd,
  input logic          ex_wr_en,
  input logic          ex_is_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wr_en,
  input logic          mem_br_taken,
  input logic [AW-1:0] wb_rd,
  input logic          wb_wr_en,
  input logic [DW-1:0] wb_data,
  input logic [DW-1:0] rf_data_a,
  input logic [1:0]    fwd_sel_a,
  input logic [1:0]    fwd_sel_b,
  input logic          hold_fetch,
  input logic          hold_decode,
  input logic          bubble_ex,
  input logic          flush_young
);
  // R3: nearest producer wins on operand A
  assert_mem_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && mem_wr_en && mem_rd != '0 && mem_rd == ex_rs) |-> fwd_sel_a == 2'b10);

  // R4: register 0 is never forwarded
  assert_zero_no_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_a != 2'b00) |-> ex_rs != '0);

  // R5: stall outputs move together
  assert_stall_coherent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |-> (hold_fetch && hold_decode));

  // R6: a non-load producer in execute alone never stalls in forwarding mode
  assert_alu_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && !ex_is_load && !mem_br_taken) |-> !bubble_ex);

  // R7: no forwarding in stall-only mode
  assert_fwd_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |-> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));

  // R8: redirect overrides stall
  assert_flush_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_br_taken |-> (flush_young && !hold_fetch && !hold_decode && !bubble_ex));

  // R9: same-cycle write visible to a read
  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wr_en && wb_rd != '0 && wb_rd == dec_rs) |-> rf_data_a == wb_data);

  // R10: register 0 reads zero
  assert_zero_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rs == '0) |-> rf_data_a == '0);

  // R11: a write is kept for the next cycle's read
  assert_write_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wb_wr_en) && $past(wb_rd) != '0 && dec_rs == $past(wb_rd)
     && !(wb_wr_en && wb_rd == dec_rs)) |-> rf_data_a == $past(wb_data));
endmodule

bind hz_pipe_ctrl hz_pipe_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .dec_rs(dec_rs), .ex_rs(ex_rs),
  .ex_rd(ex_rd), .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load), .mem_rd(mem_rd),
  .mem_wr_en(mem_wr_en), .mem_br_taken(mem_br_taken), .wb_rd(wb_rd),
  .wb_wr_en(wb_wr_en), .wb_data(wb_data), .rf_data_a(rf_data_a),
  .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .hold_fetch(hold_fetch),
  .hold_decode(hold_decode), .bubble_ex(bubble_ex), .flush_young(flush_young)
);

// File: tb/hz_pipe_ctrl_tb.sv
module hz_pipe_ctrl_tb_top;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd_en = 1'b1;
  logic [AW-1:0] dec_rs = '0, dec_rt = '0, ex_rs = '0, ex_rt = '0, ex_rd = '0;
  logic ex_wr_en = 1'b0, ex_is_load = 1'b0;
  logic [AW-1:0] mem_rd = '0, wb_rd = '0;
  logic mem_wr_en = 1'b0, mem_br_taken = 1'b0, wb_wr_en = 1'b0;
  logic [DW-1:0] wb_data = '0;
  logic [DW-1:0] rf_data_a, rf_data_b;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic hold_fetch, hold_decode, bubble_ex, flush_young;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hz_pipe_ctrl #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_wr_en(ex_wr_en),
    .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_wr_en(mem_wr_en),
    .mem_br_taken(mem_br_taken), .wb_rd(wb_rd), .wb_wr_en(wb_wr_en),
    .wb_data(wb_data), .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .hold_fetch(hold_fetch),
    .hold_decode(hold_decode), .bubble_ex(bubble_ex), .flush_young(flush_young)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int r);
    return 32'h1357_0000 + DW'(r) * 32'h0001_0203;
  endfunction

  // Expected select from R1/R2/R3/R4/R7
  function automatic int exp_sel(input bit f, input int src, input int mr, input bit mw,
                                 input int wr, input bit ww);
    if (!f || src == 0) return 0;
    if (mw && mr == src) return 2;
    if (ww && wr == src) return 1;
    return 0;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state of the register file
    for (int r = 0; r < 32; r++) begin
      dec_rs = AW'(r); dec_rt = AW'(31 - r);
      #2;
      check("R11 reset read a", rf_data_a, 0);
      check("R11 reset read b", rf_data_b, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R9/R10/R11: write every register, bypass in the writing cycle
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      wb_wr_en = 1'b1; wb_rd = AW'(r); wb_data = pattern(r);
      dec_rs = AW'(r); dec_rt = AW'(r);
      #2;
      if (r == 0) check("R10 write to r0 reads zero", rf_data_a, 0);
      else        check("R9 same-cycle bypass", rf_data_b, pattern(r));
    end
    @(negedge clk);
    wb_wr_en = 1'b0;
    for (int r = 0; r < 32; r++) begin
      dec_rs = AW'(r); dec_rt = AW'((r + 5) % 32);
      #2;
      check("R11/R10 stored read a", rf_data_a, (r == 0) ? 0 : pattern(r));
      check("R11 stored read b", rf_data_b, ((r + 5) % 32 == 0) ? 0 : pattern((r + 5) % 32));
    end

    // R1/R2/R3/R4/R7: forwarding select sweep over registers 0..3
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 4; s++)
        for (int mr = 0; mr < 4; mr++)
          for (int mw = 0; mw < 2; mw++)
            for (int wr = 0; wr < 4; wr++)
              for (int ww = 0; ww < 2; ww++) begin
                @(negedge clk);
                fwd_en = f[0]; ex_rs = AW'(s); ex_rt = AW'(3 - s);
                mem_rd = AW'(mr); mem_wr_en = mw[0];
                wb_rd = AW'(wr); wb_wr_en = ww[0]; wb_data = 32'hCAFE_0000 + 32'(wr);
                #2;
                check("R1/R2/R3/R4/R7 sel_a", fwd_sel_a, exp_sel(f[0], s, mr, mw[0], wr, ww[0]));
                check("R1/R2/R3/R4/R7 sel_b", fwd_sel_b, exp_sel(f[0], 3 - s, mr, mw[0], wr, ww[0]));
              end
    @(negedge clk);
    wb_wr_en = 1'b0;

    // R4/R5/R6/R7/R8: hold, bubble and flush sweep (combinational)
    for (int f = 0; f < 2; f++)
      for (int rs = 0; rs < 4; rs++)
        for (int rt = 0; rt < 4; rt++)
          for (int xr = 0; xr < 4; xr++)
            for (int xw = 0; xw < 2; xw++)
              for (int xl = 0; xl < 2; xl++)
                for (int mr = 0; mr < 4; mr++)
                  for (int mw = 0; mw < 2; mw++)
                    for (int br = 0; br < 2; br++) begin
                      bit ex_dep, mem_dep, stall;
                      fwd_en = f[0]; dec_rs = AW'(rs); dec_rt = AW'(rt);
                      ex_rd = AW'(xr); ex_wr_en = xw[0]; ex_is_load = xl[0];
                      mem_rd = AW'(mr); mem_wr_en = mw[0]; mem_br_taken = br[0];
                      #1;
                      ex_dep  = xw[0] && xr != 0 && (xr == rs || xr == rt);
                      mem_dep = mw[0] && mr != 0 && (mr == rs || mr == rt);
                      stall = f[0] ? (ex_dep && xl[0]) : (ex_dep || mem_dep);
                      if (br[0]) stall = 1'b0;
                      check("R5/R6/R7/R4 hold_fetch", hold_fetch, stall);
                      check("R5 hold_decode", hold_decode, stall);
                      check("R5/R7 bubble_ex", bubble_ex, stall);
                      check("R8 flush_young", flush_young, br);
                    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule